// File: doc/BRIEF.md
# Serial Configuration Chain Master

This block drives a daisy-chained, two-wire serial configuration bus. It owns three wires. A control line and a downlink data line go out to the first satellite, and an uplink data line comes back from the end of the chain. A transaction starts with a one-cycle pulse on the parallel command port. The pulse carries a satellite id, a register address, the transfer direction and the write data. The master raises the control line, shifts out a framed command with its parity bits, and then hunts for the response on the uplink. The response can arrive after any number of forwarding delays, because each satellite in the chain adds one register of delay.

The response is decoded into status flags, read data and two integrity checks. One check covers the response header parity; the other covers the read data group parities. The master completes the transaction only after it sees the closing zero-then-one pattern, and it then drops the control line. That falling edge is what returns every satellite to its idle state. A programmable cycle limit aborts a transaction whose response never finishes.

Top module: `cfgchain_master`

## Requirements
- R1: After a synchronous reset, ctl_out, dl_out, busy and done are 0 and every response output is 0.
- R2: On an accepted command, ctl_out rises on the same edge while dl_out is still 0. On the next edges dl_out carries the frame in this order: a 1 start bit, the satellite id MSB first, the register address MSB first, the direction bit (1 = read), then the header parity bit. ctl_out stays high until completion.
- R3: The header parity bit makes the XOR of satellite id, address, direction bit and parity bit equal 0.
- R4: A write frame continues with the 64 write-data bits, MSB first, followed by one even-parity bit per 16-bit group. The first of these parity bits covers bits 63:48. A read frame ends after the header parity bit. dl_out is 0 whenever no frame bit is being sent.
- R5: After the frame, the master treats the first 1 sampled on ul_in as the response start bit, however many 0 cycles come before it. Then it takes, in order: the id (4 bits), the address (6 bits), and four flags reported on rsp_hdr_err, rsp_wpar_err, rsp_acc_err and rsp_addr_err. A response parity bit follows the flags.
- R6: For a read whose four flags are all 0, the master takes 64 data bits and 4 group parity bits (same order as R4) and presents the data on rsp_rdata. For every other response no data is expected, and rsp_rdata is 0.
- R7: rsp_par_err is 1 exactly when the XOR of the echoed id, the address, the four flags and the response parity bit is 1.
- R8: rsp_dpar_err is 1 when any received read-data group fails even parity with its parity bit. It is 0 for responses without data.
- R9: Completion requires a 0 on ul_in followed later by a 1, after the response body; extra 1 bits before that 0 do not complete. On the edge that samples the closing 1, done pulses for one cycle, ctl_out falls and busy falls.
- R10: If the response has not completed by the tmo_limit-th edge after the edge that drove the last downlink bit, that edge ends the transaction. done pulses, ctl_out falls, rsp_timeout is 1, and all flags and rsp_rdata are 0.
- R11: cmd_start is ignored while busy: no second frame is sent and ctl_out stays low after the first completion.
- R12: busy is 1 from the edge that accepts a command until the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Command pulse, taken when not busy |
| cmd_sat | input | SAT_W | Target satellite id |
| cmd_reg | input | REG_W | Target register address |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_wdata | input | DATA_W | Write data |
| tmo_limit | input | TO_W | Response timeout in cycles |
| ctl_out | output | 1 | Control line to the chain |
| dl_out | output | 1 | Downlink data line |
| ul_in | input | 1 | Uplink data line from the chain end |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data |
| rsp_hdr_err | output | 1 | Satellite saw a header parity error |
| rsp_wpar_err | output | 1 | Satellite saw a write data parity error |
| rsp_acc_err | output | 1 | Access violation reported |
| rsp_addr_err | output | 1 | Invalid register address reported |
| rsp_par_err | output | 1 | Response header parity mismatch |
| rsp_dpar_err | output | 1 | Read data group parity mismatch |
| rsp_timeout | output | 1 | Transaction aborted by timeout |

## Verification
The bench builds the block with its default widths: a 4-bit id, a 6-bit address, 64-bit data in four 16-bit parity groups, and a 16-bit timeout. These match the frame layout, so full 81-bit write frames and 84-bit read responses are compared bit for bit. A behavioural satellite in the bench varies the leading-zero delay, the flag patterns, single corrupted parity bits and stray ones before the trailer. A timeout limit of 20 makes the abort edge exactly countable.

// File: rtl/cfgchain_pkg.sv
`timescale 1ns/1ps
package cfgchain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV,
    ST_TRAIL
  } mst_state_e;
endpackage

// File: rtl/cfgchain_dn_ser.sv
`timescale 1ns/1ps
module cfgchain_dn_ser #(
  parameter int SAT_W  = 4,
  parameter int REG_W  = 6,
  parameter int DATA_W = 64,
  parameter int GRP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [SAT_W-1:0]  sat_id,
  input  logic [REG_W-1:0]  reg_addr,
  input  logic              rnw,
  input  logic [DATA_W-1:0] wdata,
  output logic              dl,
  output logic              last
);
  localparam int NGRP    = DATA_W / GRP_W;
  localparam int HDR_LEN = SAT_W + REG_W + 3;
  localparam int FRM_LEN = HDR_LEN + DATA_W + NGRP;
  localparam int CW      = $clog2(FRM_LEN + 1);

  logic [NGRP-1:0]    gpar;
  logic [FRM_LEN-1:0] frame;
  logic [FRM_LEN-1:0] sr;
  logic [CW-1:0]      left;
  logic [CW-1:0]      len;
  logic               dl_q;

  // group parity, first sent bit covers the top group
  for (genvar g = 0; g < NGRP; g++) begin : g_wpar
    assign gpar[NGRP-1-g] = ^wdata[DATA_W-1-g*GRP_W -: GRP_W];
  end

  assign frame = {1'b1, sat_id, reg_addr, rnw, ^{sat_id, reg_addr, rnw}, wdata, gpar};
  assign len   = rnw ? CW'(HDR_LEN) : CW'(FRM_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      left <= '0;
      dl_q <= 1'b0;
    end else if (load) begin
      sr   <= frame;
      left <= len;
      dl_q <= 1'b0;
    end else if (shift) begin
      dl_q <= sr[FRM_LEN-1];
      sr   <= {sr[FRM_LEN-2:0], 1'b0};
      left <= left - CW'(1);
    end else begin
      dl_q <= 1'b0;
    end
  end

  assign dl   = dl_q;
  assign last = (left == CW'(1));
endmodule

// File: rtl/cfgchain_up_deser.sv
`timescale 1ns/1ps
module cfgchain_up_deser #(
  parameter int SAT_W  = 4,
  parameter int REG_W  = 6,
  parameter int DATA_W = 64,
  parameter int GRP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift,
  input  logic              bit_in,
  output logic              hdr_last,
  output logic              dat_last,
  output logic [3:0]        flags_early,
  output logic [3:0]        flags,
  output logic              par_bad,
  output logic [DATA_W-1:0] rdata,
  output logic              dpar_bad
);
  localparam int NGRP = DATA_W / GRP_W;
  localparam int UH   = SAT_W + REG_W + 5;   // after the start bit
  localparam int UD   = DATA_W + NGRP;
  localparam int UT   = UH + UD;
  localparam int CW   = $clog2(UT + 1);

  logic [UH-1:0]   hdr_sr;
  logic [UD-1:0]   dat_sr;
  logic [CW-1:0]   cnt;
  logic [NGRP-1:0] grp_bad;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hdr_sr <= '0;
      dat_sr <= '0;
      cnt    <= '0;
    end else if (shift) begin
      if (cnt < CW'(UH)) hdr_sr <= {hdr_sr[UH-2:0], bit_in};
      else               dat_sr <= {dat_sr[UD-2:0], bit_in};
      cnt <= cnt + CW'(1);
    end
  end

  assign hdr_last    = (cnt == CW'(UH - 1));
  assign dat_last    = (cnt == CW'(UT - 1));
  assign flags_early = hdr_sr[3:0];
  assign flags       = hdr_sr[4:1];
  assign par_bad     = ^hdr_sr;
  assign rdata       = dat_sr[UD-1:NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_rpar
    assign grp_bad[g] = (^dat_sr[UD-1-g*GRP_W -: GRP_W]) ^ dat_sr[NGRP-1-g];
  end
  assign dpar_bad = |grp_bad;
endmodule

// File: rtl/cfgchain_tmo.sv
`timescale 1ns/1ps
module cfgchain_tmo #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            hit
);
  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + TO_W'(1);
  end

  assign hit = run && (({1'b0, cnt} + (TO_W+1)'(1)) >= {1'b0, limit});
endmodule

// File: rtl/cfgchain_master.sv
`timescale 1ns/1ps
module cfgchain_master #(
  parameter int SAT_W  = 4,
  parameter int REG_W  = 6,
  parameter int DATA_W = 64,
  parameter int GRP_W  = 16,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [SAT_W-1:0]  cmd_sat,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic              cmd_rnw,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [TO_W-1:0]   tmo_limit,
  output logic              ctl_out,
  output logic              dl_out,
  input  logic              ul_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hdr_err,
  output logic              rsp_wpar_err,
  output logic              rsp_acc_err,
  output logic              rsp_addr_err,
  output logic              rsp_par_err,
  output logic              rsp_dpar_err,
  output logic              rsp_timeout
);
  import cfgchain_pkg::*;

  mst_state_e st, st_nx;
  logic start_ok, tx_last, hdr_last, dat_last, tmo_hit, tmo_run;
  logic fin, abt, to_trail, set_long;
  logic rnw_q, long_q, seen0, ctl_q, busy_q, done_q;
  logic [3:0] flags_early, flags;
  logic par_bad, dpar_bad;
  logic [DATA_W-1:0] rdata;

  assign start_ok = (st == ST_IDLE) && cmd_start;
  assign tmo_run  = (st == ST_WAIT) || (st == ST_RECV) || (st == ST_TRAIL);

  cfgchain_dn_ser #(.SAT_W(SAT_W), .REG_W(REG_W), .DATA_W(DATA_W), .GRP_W(GRP_W)) u_tx (
    .clk(clk), .rst(rst), .load(start_ok), .shift(st == ST_SEND),
    .sat_id(cmd_sat), .reg_addr(cmd_reg), .rnw(cmd_rnw), .wdata(cmd_wdata),
    .dl(dl_out), .last(tx_last)
  );

  cfgchain_up_deser #(.SAT_W(SAT_W), .REG_W(REG_W), .DATA_W(DATA_W), .GRP_W(GRP_W)) u_rx (
    .clk(clk), .rst(rst), .clr(start_ok), .shift(st == ST_RECV), .bit_in(ul_in),
    .hdr_last(hdr_last), .dat_last(dat_last), .flags_early(flags_early),
    .flags(flags), .par_bad(par_bad), .rdata(rdata), .dpar_bad(dpar_bad)
  );

  cfgchain_tmo #(.TO_W(TO_W)) u_tmo (
    .clk(clk), .rst(rst), .run(tmo_run), .limit(tmo_limit), .hit(tmo_hit)
  );

  always_comb begin
    st_nx    = st;
    fin      = 1'b0;
    abt      = 1'b0;
    to_trail = 1'b0;
    set_long = 1'b0;
    case (st)
      ST_IDLE:  if (cmd_start) st_nx = ST_SEND;
      ST_SEND:  if (tx_last) st_nx = ST_WAIT;
      ST_WAIT: begin
        if (tmo_hit)    abt = 1'b1;
        else if (ul_in) st_nx = ST_RECV;
      end
      ST_RECV: begin
        if (tmo_hit) abt = 1'b1;
        else if (hdr_last) begin
          if (rnw_q && (flags_early == 4'b0000)) set_long = 1'b1;
          else                                   to_trail = 1'b1;
        end else if (dat_last) to_trail = 1'b1;
      end
      ST_TRAIL: begin
        if (ul_in && seen0) fin = 1'b1;
        else if (tmo_hit)   abt = 1'b1;
      end
      default: st_nx = ST_IDLE;
    endcase
    if (to_trail)   st_nx = ST_TRAIL;
    if (fin || abt) st_nx = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      rnw_q        <= 1'b0;
      long_q       <= 1'b0;
      seen0        <= 1'b0;
      ctl_q        <= 1'b0;
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      rsp_rdata    <= '0;
      rsp_hdr_err  <= 1'b0;
      rsp_wpar_err <= 1'b0;
      rsp_acc_err  <= 1'b0;
      rsp_addr_err <= 1'b0;
      rsp_par_err  <= 1'b0;
      rsp_dpar_err <= 1'b0;
      rsp_timeout  <= 1'b0;
    end else begin
      st     <= st_nx;
      done_q <= fin || abt;
      if (start_ok) begin
        rnw_q  <= cmd_rnw;
        long_q <= 1'b0;
        ctl_q  <= 1'b1;
        busy_q <= 1'b1;
      end
      if (set_long) long_q <= 1'b1;
      if (to_trail) seen0 <= 1'b0;
      else if ((st == ST_TRAIL) && !ul_in) seen0 <= 1'b1;
      if (fin || abt) begin
        ctl_q  <= 1'b0;
        busy_q <= 1'b0;
      end
      if (fin) begin
        rsp_hdr_err  <= flags[3];
        rsp_wpar_err <= flags[2];
        rsp_acc_err  <= flags[1];
        rsp_addr_err <= flags[0];
        rsp_par_err  <= par_bad;
        rsp_rdata    <= long_q ? rdata : '0;
        rsp_dpar_err <= long_q && dpar_bad;
        rsp_timeout  <= 1'b0;
      end else if (abt) begin
        rsp_hdr_err  <= 1'b0;
        rsp_wpar_err <= 1'b0;
        rsp_acc_err  <= 1'b0;
        rsp_addr_err <= 1'b0;
        rsp_par_err  <= 1'b0;
        rsp_rdata    <= '0;
        rsp_dpar_err <= 1'b0;
        rsp_timeout  <= 1'b1;
      end
    end
  end

  assign ctl_out = ctl_q;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/cfgchain_master_chk.sv
`timescale 1ns/1ps
module cfgchain_master_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_out,
  input logic              dl_out,
  input logic              busy,
  input logic              done,
  input logic              rsp_timeout,
  input logic              rsp_par_err,
  input logic              rsp_hdr_err,
  input logic [DATA_W-1:0] rsp_rdata
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_DROPS_CTL: assert property (@(posedge clk) disable iff (rst)
    done |-> (!ctl_out && !busy)); // R12

  AST_DL_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ctl_out |-> !dl_out); // R4

  AST_CTL_BEFORE_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_out) |-> !dl_out); // R2

  AST_TMO_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (done && rsp_timeout) |-> (!rsp_par_err && !rsp_hdr_err && (rsp_rdata == '0))); // R10
endmodule

bind cfgchain_master cfgchain_master_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .ctl_out(ctl_out), .dl_out(dl_out), .busy(busy),
  .done(done), .rsp_timeout(rsp_timeout), .rsp_par_err(rsp_par_err),
  .rsp_hdr_err(rsp_hdr_err), .rsp_rdata(rsp_rdata)
);

// File: tb/cfgchain_master_tb_top.sv
`timescale 1ns/1ps
module cfgchain_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic [3:0]  cmd_sat = '0;
  logic [5:0]  cmd_reg = '0;
  logic        cmd_rnw = 1'b0;
  logic [63:0] cmd_wdata = '0;
  logic [15:0] tmo_limit = 16'd1000;
  logic        ul_in = 1'b0;
  logic        ctl_out, dl_out, busy, done;
  logic [63:0] rsp_rdata;
  logic rsp_hdr_err, rsp_wpar_err, rsp_acc_err, rsp_addr_err;
  logic rsp_par_err, rsp_dpar_err, rsp_timeout;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cfgchain_master dut_i (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_sat(cmd_sat),
    .cmd_reg(cmd_reg), .cmd_rnw(cmd_rnw), .cmd_wdata(cmd_wdata),
    .tmo_limit(tmo_limit), .ctl_out(ctl_out), .dl_out(dl_out), .ul_in(ul_in),
    .busy(busy), .done(done), .rsp_rdata(rsp_rdata), .rsp_hdr_err(rsp_hdr_err),
    .rsp_wpar_err(rsp_wpar_err), .rsp_acc_err(rsp_acc_err),
    .rsp_addr_err(rsp_addr_err), .rsp_par_err(rsp_par_err),
    .rsp_dpar_err(rsp_dpar_err), .rsp_timeout(rsp_timeout)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] gpar(input logic [63:0] d);
    logic [3:0] p;
    for (int g = 0; g < 4; g++) p[3-g] = ^d[63-16*g -: 16];
    return p;
  endfunction

  function automatic logic [15:0] up_head(input logic [3:0] id, input logic [5:0] ad,
                                          input logic [3:0] fl, input logic flip);
    return {1'b1, id, ad, fl, (^{id, ad, fl}) ^ flip};
  endfunction

  task automatic issue(input logic [3:0] id, input logic [5:0] ad, input logic rnw,
                       input logic [63:0] wd);
    @(negedge clk);
    cmd_sat = id; cmd_reg = ad; cmd_rnw = rnw; cmd_wdata = wd; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    check("R2 ctl high on accept", {63'd0, ctl_out}, 64'd1);
    check("R2 dl low before start bit", {63'd0, dl_out}, 64'd0);
    check("R12 busy after accept", {63'd0, busy}, 64'd1);
  endtask

  task automatic grab(input logic rnw, output logic [80:0] got);
    int len;
    len = rnw ? 13 : 81;
    got = '0;
    for (int k = 0; k < 8 && dl_out !== 1'b1; k++) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      got[80-i] = dl_out;
      if (i < len - 1) @(negedge clk);
    end
  endtask

  task automatic send_bits(input logic [127:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      ul_in = v[i];
    end
  endtask

  task automatic close_check(input string tag);
    check({tag, " R9 ctl still high before closing 1"}, {63'd0, ctl_out}, 64'd1);
    check({tag, " R9 no early done"}, {63'd0, done}, 64'd0);
    @(posedge clk); #1;
    check({tag, " R9 done after closing 1"}, {63'd0, done}, 64'd1);
    check({tag, " R9 ctl dropped"}, {63'd0, ctl_out}, 64'd0);
    check({tag, " R12 busy cleared"}, {63'd0, busy}, 64'd0);
    @(negedge clk);
    ul_in = 1'b0;
  endtask

  task automatic run_txn(input string tag, input logic [3:0] id, input logic [5:0] ad,
                         input logic rnw, input logic [63:0] wd, input logic [3:0] fl,
                         input logic flip, input int lead, input logic [63:0] rd,
                         input logic [3:0] pmask, input int ones);
    logic [80:0]  got;
    logic [80:0]  exp;
    logic [127:0] v;
    int n;
    issue(id, ad, rnw, wd);
    grab(rnw, got);
    exp = {1'b1, id, ad, rnw, ^{id, ad, rnw}, wd, gpar(wd)};
    check({tag, " R2 header bits"}, {51'd0, got[80:68]}, {51'd0, exp[80:68]});
    check({tag, " R3 header parity even"}, {63'd0, ^got[79:68]}, 64'd0);
    if (!rnw) begin
      check({tag, " R4 write data"}, got[67:4], wd);
      check({tag, " R4 group parity"}, {60'd0, got[3:0]}, {60'd0, gpar(wd)});
    end
    @(negedge clk);
    check({tag, " R4 dl low after frame"}, {63'd0, dl_out}, 64'd0);
    repeat (lead) @(negedge clk);
    v = {112'd0, up_head(id, ad, fl, flip)};
    n = 16;
    if (rnw && fl == 4'b0000) begin
      v = (v << 68) | {60'd0, rd, gpar(rd) ^ pmask};
      n += 68;
    end
    for (int i = 0; i < ones; i++) begin
      v = (v << 1) | 128'd1;
      n++;
    end
    v = (v << 2) | 128'd1;
    n += 2;
    send_bits(v, n);
    close_check(tag);
  endtask

  task automatic t_reset();
    check("R1 ctl", {63'd0, ctl_out}, 64'd0);
    check("R1 dl", {63'd0, dl_out}, 64'd0);
    check("R1 busy/done", {62'd0, busy, done}, 64'd0);
    check("R1 rdata", rsp_rdata, 64'd0);
    check("R1 flags", {57'd0, rsp_hdr_err, rsp_wpar_err, rsp_acc_err, rsp_addr_err,
                       rsp_par_err, rsp_dpar_err, rsp_timeout}, 64'd0);
  endtask

  task automatic t_write_ok();
    run_txn("wr", 4'h5, 6'h2A, 1'b0, 64'hDEAD_BEEF_0123_4567, 4'b0000, 1'b0, 3, 64'd0, 4'd0, 0);
    check("R5 write flags clear", {60'd0, rsp_hdr_err, rsp_wpar_err, rsp_acc_err, rsp_addr_err}, 64'd0);
    check("R6 write has no rdata", rsp_rdata, 64'd0);
    check("R7 write parity ok", {63'd0, rsp_par_err}, 64'd0);
    check("R10 no timeout", {63'd0, rsp_timeout}, 64'd0);
  endtask

  task automatic t_read_ok();
    run_txn("rd", 4'hA, 6'h11, 1'b1, 64'd0, 4'b0000, 1'b0, 0, 64'h0123_4567_89AB_CDEF, 4'd0, 0);
    check("R6 read data", rsp_rdata, 64'h0123_4567_89AB_CDEF);
    check("R8 read data parity ok", {63'd0, rsp_dpar_err}, 64'd0);
    check("R7 read parity ok", {63'd0, rsp_par_err}, 64'd0);
  endtask

  task automatic t_read_flag();
    run_txn("rdacc", 4'h3, 6'h3F, 1'b1, 64'd0, 4'b0010, 1'b0, 5, 64'd0, 4'd0, 0);
    check("R5 access flag", {60'd0, rsp_hdr_err, rsp_wpar_err, rsp_acc_err, rsp_addr_err}, 64'h2);
    check("R6 no data after flag", rsp_rdata, 64'd0);
    check("R8 no dpar without data", {63'd0, rsp_dpar_err}, 64'd0);
  endtask

  task automatic t_write_flags();
    run_txn("wrfl", 4'hF, 6'h00, 1'b0, 64'hFFFF_0000_FFFF_0001, 4'b1101, 1'b0, 1, 64'd0, 4'd0, 0);
    check("R5 flag order", {60'd0, rsp_hdr_err, rsp_wpar_err, rsp_acc_err, rsp_addr_err}, 64'hD);
    check("R7 parity ok with flags", {63'd0, rsp_par_err}, 64'd0);
  endtask

  task automatic t_dpar();
    run_txn("dpar", 4'h9, 6'h05, 1'b1, 64'd0, 4'b0000, 1'b0, 2, 64'hAAAA_5555_1234_8000, 4'b0100, 0);
    check("R8 group error seen", {63'd0, rsp_dpar_err}, 64'd1);
    check("R6 data still delivered", rsp_rdata, 64'hAAAA_5555_1234_8000);
    check("R7 header unaffected", {63'd0, rsp_par_err}, 64'd0);
  endtask

  task automatic t_rpar();
    run_txn("rpar", 4'h6, 6'h21, 1'b0, 64'h1, 4'b0000, 1'b1, 0, 64'd0, 4'd0, 0);
    check("R7 response parity error", {63'd0, rsp_par_err}, 64'd1);
  endtask

  task automatic t_trail();
    run_txn("trail", 4'h1, 6'h1E, 1'b1, 64'd0, 4'b0000, 1'b0, 1, 64'hFEDC_BA98_7654_3210, 4'd0, 3);
    check("R9 data with stray ones", rsp_rdata, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_timeout();
    logic [80:0] got;
    int n;
    tmo_limit = 16'd20;
    issue(4'h2, 6'h0C, 1'b1, 64'd0);
    grab(1'b1, got);
    n = 0;
    while (n < 200) begin
      @(posedge clk); #1;
      n++;
      if (done === 1'b1) break;
    end
    check("R10 abort edge", 64'(n), 64'd20);
    check("R10 timeout flag", {63'd0, rsp_timeout}, 64'd1);
    check("R10 ctl dropped", {63'd0, ctl_out}, 64'd0);
    check("R10 flags clear", {59'd0, rsp_hdr_err, rsp_wpar_err, rsp_acc_err, rsp_addr_err, rsp_par_err}, 64'd0);
    tmo_limit = 16'd1000;
  endtask

  task automatic t_busy_ignore();
    logic [80:0] got;
    logic bad;
    issue(4'h7, 6'h07, 1'b1, 64'd0);
    grab(1'b1, got);
    @(negedge clk);
    cmd_sat = 4'h8; cmd_reg = 6'h30; cmd_rnw = 1'b0; cmd_wdata = 64'h55; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    check("R11 still busy", {63'd0, busy}, 64'd1);
    send_bits({44'd0, up_head(4'h7, 6'h07, 4'b0000, 1'b0), 64'h0000_0000_C0DE_0001,
               gpar(64'h0000_0000_C0DE_0001), 2'b01}, 86);
    close_check("busy");
    check("R11 first read data", rsp_rdata, 64'h0000_0000_C0DE_0001);
    bad = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (ctl_out !== 1'b0 || dl_out !== 1'b0) bad = 1'b1;
    end
    check("R11 no second frame", {63'd0, bad}, 64'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_ok();
    t_read_ok();
    t_read_flag();
    t_write_flags();
    t_dpar();
    t_rpar();
    t_trail();
    t_timeout();
    t_busy_ignore();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule